// File: doc/BRIEF.md
# Weighted-Sum Accumulator with Ratio Output

This block integrates a stream of samples, each paired with a weight, over windows whose boundaries are set by a restart input. Every clock it forms the product of the sample and the weight. It adds that product into a running product sum and adds the weight into a running weight sum. When restart is asserted, the block closes the current window and opens the next one in the same cycle. The sample present on that clock becomes the first member of the new window, so no sample falls between windows.

The ratio of the closed window is its product sum divided by its weight sum, which is the weighted mean of the samples. It is computed from the sums as they stood before the restart clock. A restoring shift-subtract divider produces the ratio, one quotient bit per clock. The result appears on `quot` with a one-cycle `quot_valid` strobe. A window whose weight sum is zero yields an all-ones result flagged by `div_zero`. A restart that arrives while a division is still running is reported on `overrun`, and the running division finishes untouched.

Top module: `wsr_top`

## Requirements
- R1: On every clock edge where `restart` is low, the product sum grows by `sample*weight` and the weight sum grows by `weight`.
- R2: On a clock edge where `restart` is high, the product sum is loaded with `sample*weight` and the weight sum with `weight`, so the new window already holds that sample.
- R3: The ratio reported for a restart is the floor of the product sum divided by the weight sum, both taken before that edge's update.
- R4: `quot` changes only in a cycle where `quot_valid` is high; otherwise it holds its last value.
- R5: For a non-zero weight sum, `quot_valid` is high exactly in the cycle after the Q_W-th clock edge following the restart edge, where Q_W = X_W+W_W+WIN_LOG2. No valid strobe is given while the divider is busy.
- R6: If the weight sum is zero at a restart accepted by an idle divider, the division is skipped: in the next cycle `quot_valid` is high, `quot` is all ones and `div_zero` is 1. `div_zero` is 0 alongside every other result.
- R7: A restart while the divider is busy raises `overrun` for the next cycle. The running division completes with its original operands, the closed window's ratio is dropped, and the sums are still reseeded as in R2.
- R8: Windows of up to 2^WIN_LOG2 samples at full-scale sample and weight do not overflow either sum.
- R9: After reset, `quot` is 0 and `quot_valid`, `div_zero` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample | input | X_W | Unsigned sample value |
| weight | input | W_W | Unsigned weight for the sample |
| restart | input | 1 | Close current window and seed a new one with this cycle's sample |
| quot | output | X_W+W_W+WIN_LOG2 | Ratio of the last completed window |
| quot_valid | output | 1 | One-cycle strobe: `quot` was just updated |
| div_zero | output | 1 | Last result came from a zero weight sum |
| overrun | output | 1 | One-cycle strobe: a restart was refused because the divider was busy |

## Verification
The bench builds the block with 4-bit samples, 4-bit weights and WIN_LOG2 = 3. This gives 11-bit product sums, 7-bit weight sums and an 11-cycle division. At that size every sample/weight pair can be swept as a one-sample window, which covers every quotient digit pattern as well as the zero-weight case. Full-scale windows of exactly eight samples reach the top of both sums. A restart is also placed deliberately inside a running division, to exercise the refusal path together with the reseeding that follows it.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  function automatic int sum_width(input int term_w, input int win_log2);
    return term_w + win_log2;
  endfunction

endpackage

// File: rtl/wsr_rst_sync.sv
module wsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wsr_accum.sv
module wsr_accum #(
  parameter int X_W = 16,
  parameter int W_W = 16,
  parameter int A_W = 48,
  parameter int B_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [X_W-1:0] sample,
  input  logic [W_W-1:0] weight,
  input  logic           restart,
  output logic [A_W-1:0] sum_a,
  output logic [B_W-1:0] sum_b
);
  localparam int P_W = X_W + W_W;

  logic [P_W-1:0] prod;
  logic [A_W-1:0] sum_a_d;
  logic [B_W-1:0] sum_b_d;
  logic           acc_en;

  // one product per cycle, shared by the seed and the add path
  always_comb begin
    prod   = sample * weight;
    acc_en = 1'b1;
    if (restart) begin
      sum_a_d = A_W'(prod);
      sum_b_d = B_W'(weight);
    end else begin
      sum_a_d = sum_a + A_W'(prod);
      sum_b_d = sum_b + B_W'(weight);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_a <= '0;
      sum_b <= '0;
    end else if (acc_en) begin
      sum_a <= sum_a_d;
      sum_b <= sum_b_d;
    end
  end
endmodule

// File: rtl/wsr_divider.sv
module wsr_divider
  import wsr_pkg::*;
#(
  parameter int N_W = 48,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic           dz,
  output logic [N_W-1:0] result
);
  localparam int CNT_W = (N_W > 1) ? $clog2(N_W) : 1;

  div_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [D_W-1:0] rem_q, rem_d;
  logic [D_W-1:0] dvs_q, dvs_d;
  logic [N_W-1:0] qsh_q, qsh_d;
  logic [N_W-1:0] res_d;
  logic           done_d, dz_d;

  logic [D_W:0]   rem_sh, diff;
  logic           ge;
  logic [N_W-1:0] q_next;

  // one restoring step per clock
  always_comb begin
    rem_sh = {rem_q, qsh_q[N_W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    ge     = (rem_sh >= {1'b0, dvs_q});
    q_next = {qsh_q[N_W-2:0], ge};
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    qsh_d  = qsh_q;
    res_d  = result;
    done_d = 1'b0;
    dz_d   = dz;
    case (st_q)
      DIV_IDLE: begin
        if (start) begin
          if (divisor == '0) begin
            res_d  = '1;
            done_d = 1'b1;
            dz_d   = 1'b1;
          end else begin
            st_d  = DIV_RUN;
            cnt_d = CNT_W'(N_W - 1);
            rem_d = '0;
            dvs_d = divisor;
            qsh_d = dividend;
          end
        end
      end
      DIV_RUN: begin
        qsh_d = q_next;
        rem_d = D_W'(ge ? diff : rem_sh);
        if (cnt_q == '0) begin
          st_d   = DIV_IDLE;
          res_d  = q_next;
          done_d = 1'b1;
          dz_d   = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DIV_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      qsh_q  <= '0;
      result <= '0;
      done   <= 1'b0;
      dz     <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      qsh_q  <= qsh_d;
      result <= res_d;
      done   <= done_d;
      dz     <= dz_d;
    end
  end

  assign busy = (st_q == DIV_RUN);
endmodule

// File: rtl/wsr_top.sv
module wsr_top
  import wsr_pkg::*;
#(
  parameter int X_W      = 16,
  parameter int W_W      = 16,
  parameter int WIN_LOG2 = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [X_W-1:0]              sample,
  input  logic [W_W-1:0]              weight,
  input  logic                        restart,
  output logic [X_W+W_W+WIN_LOG2-1:0] quot,
  output logic                        quot_valid,
  output logic                        div_zero,
  output logic                        overrun
);
  localparam int A_W = sum_width(X_W + W_W, WIN_LOG2);
  localparam int B_W = sum_width(W_W, WIN_LOG2);

  logic           rst_sync_n;
  logic [A_W-1:0] acc_a;
  logic [B_W-1:0] acc_b;
  logic           div_busy;
  logic           div_start;
  logic           ovr_d;

  wsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsr_accum #(.X_W(X_W), .W_W(W_W), .A_W(A_W), .B_W(B_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sample  (sample),
    .weight  (weight),
    .restart (restart),
    .sum_a   (acc_a),
    .sum_b   (acc_b)
  );

  // the divider samples the sums before this edge's update
  always_comb begin
    div_start = restart & ~div_busy;
    ovr_d     = restart & div_busy;
  end

  wsr_divider #(.N_W(A_W), .D_W(B_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (div_start),
    .dividend (acc_a),
    .divisor  (acc_b),
    .busy     (div_busy),
    .done     (quot_valid),
    .dz       (div_zero),
    .result   (quot)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) overrun <= 1'b0;
    else             overrun <= ovr_d;
  end
endmodule

// File: rtl/wsr_check.sv
module wsr_check #(
  parameter int W_W = 16,
  parameter int B_W = 32,
  parameter int Q_W = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           restart,
  input logic [W_W-1:0] weight,
  input logic [B_W-1:0] sum_b,
  input logic           busy,
  input logic [Q_W-1:0] quot,
  input logic           quot_valid,
  input logic           div_zero,
  input logic           overrun
);
  a_r1_weight_accum: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> sum_b == B_W'($past(sum_b) + B_W'($past(weight))));

  a_r2_weight_seed: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> sum_b == B_W'($past(weight)));

  a_r4_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !quot_valid |-> $stable(quot));

  a_r5_no_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !quot_valid);

  a_r6_zero_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (quot_valid && div_zero) |-> (&quot));

  a_r6_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !busy && sum_b == '0) |=> (quot_valid && div_zero));

  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && busy) |=> overrun);

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy) && $past(restart));
endmodule

bind wsr_top wsr_check #(.W_W(W_W), .B_W(B_W), .Q_W(A_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .restart    (restart),
  .weight     (weight),
  .sum_b      (acc_b),
  .busy       (div_busy),
  .quot       (quot),
  .quot_valid (quot_valid),
  .div_zero   (div_zero),
  .overrun    (overrun)
);

// File: tb/wsr_top_bench.sv
module wsr_top_bench;
  localparam int XW = 4;
  localparam int WW = 4;
  localparam int WL = 3;
  localparam int QW = XW + WW + WL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [XW-1:0] sample;
  logic [WW-1:0] weight;
  logic          restart;
  logic [QW-1:0] quot;
  logic          quot_valid, div_zero, overrun;

  int     tests = 0;
  int     fails = 0;
  longint ma = 0, mb = 0, snap_a = 0, snap_b = 0;
  logic [QW-1:0] prev_quot = '0;

  always #5 clk = ~clk;

  wsr_top #(.X_W(XW), .W_W(WW), .WIN_LOG2(WL)) u_wsr_top (
    .clk(clk), .rst_n(rst_n), .sample(sample), .weight(weight),
    .restart(restart), .quot(quot), .quot_valid(quot_valid),
    .div_zero(div_zero), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at a negedge, commit at posedge, return at the next negedge
  task automatic step(input int x, input int y, input bit r);
    sample  = XW'(x);
    weight  = WW'(y);
    restart = r;
    @(posedge clk);
    if (r) begin
      snap_a = ma; snap_b = mb;
      ma = x * y;  mb = y;
    end else begin
      ma += x * y; mb += y;
    end
    @(negedge clk);
  endtask

  // called right after a restart step accepted by an idle divider
  task automatic finish_op(input string req);
    int     lat;
    int     c;
    bit     moved;
    longint expq;
    lat   = (snap_b == 0) ? 1 : QW + 1;
    c     = 1;
    moved = 1'b0;
    while (!quot_valid && c < QW + 6) begin
      if (quot !== prev_quot) moved = 1'b1;
      step(0, 0, 1'b0);
      c++;
    end
    expq = (snap_b == 0) ? (64'd1 << QW) - 1 : snap_a / snap_b;
    check(c == lat, "R5", "valid latency", c, lat);
    check(quot == QW'(expq), (snap_b == 0) ? "R6" : req, "quotient", quot, expq);
    check(div_zero == (snap_b == 0), "R6", "div_zero", div_zero, snap_b == 0);
    check(!moved, "R4", "quot moved before valid", moved, 0);
    prev_quot = quot;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample = '0; weight = '0; restart = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(quot == '0, "R9", "quot", quot, 0);
    check(!quot_valid && !div_zero && !overrun, "R9", "flags",
          {quot_valid, div_zero, overrun}, 0);

    // empty first window: zero divisor (R6)
    step(0, 0, 1'b1);
    finish_op("R6");

    // every sample/weight pair as a one-sample window (R2, R3)
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(x, y, 1'b1);
        finish_op("R2");
      end
    end

    // multi-sample windows of varied length (R1, R3)
    for (int len = 2; len <= 8; len++) begin
      step((len * 3) % 16, (len * 5 + 1) % 16, 1'b1);
      finish_op("R3");
      for (int i = 1; i < len; i++) step((i * 7 + len) % 16, (i * 5 + 3 * len) % 16, 1'b0);
    end
    step(1, 1, 1'b1);
    finish_op("R1");

    // full-scale window of 8 samples (R8)
    step(15, 15, 1'b1);
    finish_op("R1");
    for (int i = 1; i < 8; i++) step(15, 15, 1'b0);
    step(0, 0, 1'b1);
    finish_op("R8");
    check(snap_a == 1800 && snap_b == 120, "R8", "model window", snap_a, 1800);

    // R4: quot holds across idle accumulation
    for (int i = 0; i < 5; i++) step(i + 2, i + 1, 1'b0);
    check(quot == prev_quot && !quot_valid, "R4", "quot held", quot, prev_quot);

    // R7 overrun: restart while busy
    step(5, 4, 1'b1);
    finish_op("R3");
    step(9, 2, 1'b0);               // window now 38 / 6
    step(1, 1, 1'b1);               // division of 38/6 begins
    step(0, 0, 1'b0);
    check(!overrun, "R7", "overrun before refused restart", overrun, 0);
    step(2, 3, 1'b1);               // refused, but sums reseed to 6 / 3
    check(overrun, "R7", "overrun strobe", overrun, 1);
    begin
      int c;
      c = 3;
      while (!quot_valid && c < QW + 6) begin step(0, 0, 1'b0); c++; end
      check(c == QW + 1, "R7", "running division latency", c, QW + 1);
      check(quot == QW'(6), "R7", "running division result", quot, 6);
      check(!overrun, "R7", "overrun single cycle", overrun, 0);
      prev_quot = quot;
    end
    step(0, 0, 1'b1);
    finish_op("R7");
    check(quot == QW'(2), "R7", "reseeded window", quot, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule